// File: doc/BRIEF.md
# Host Command Vector Register

This block is a small control register through which an external host asks an embedded processor core to take a vectored interrupt. The host writes a seven-bit vector, a non-maskable flag and a command bit. Setting the command bit raises an interrupt request toward the core. The request carries the stored vector and flag. It stays raised until the core accepts it, and at that point the command bit clears by itself. This path does not depend on any data-transfer path of the host port.

On the host side there is a single-cycle access strobe, a write flag, an address, four active-high byte enables and a 32-bit data bus. A mode input selects one of three views of the register.

- In the 32-bit bus mode, writes follow the byte enables, and the register is selected by one full address.
- In the 24-bit and 16-bit bus modes, a write loads the low lanes that the mode carries and zero-fills the rest. A read in these modes shows only those lanes. The register is selected by matching address bits 10:3 against a configured base.

The core side is a valid/ready pair. `irq_valid` is the request. `irq_ready` is the acknowledge, and a transfer happens on any clock edge where both are high. The request is never withdrawn because of back-pressure: while `irq_ready` stays low, the request and its payload stay put. Only a host write can change the payload while the request is pending.

Top module: `hcv_top`

## Requirements
- R1: After reset the command bit, vector and non-maskable bit are zero, `irq_valid` is low, and a read returns zero.
- R2: The command bit is bit 0, the vector is bits 7:1 and the non-maskable bit is bit 15. `irq_valid`, `irq_vector` and `irq_nmi` show the stored command bit, vector and non-maskable bit from the edge after a write.
- R3: In mode 2'b01 (32-bit), byte lane i is bits 8i+7:8i and is written only when `host_be[i]` is 1. A lane whose enable is 0 keeps its previous contents.
- R4: In mode 2'b10 (24-bit), a write loads lanes 0 to 2 from `host_wdata` whatever the byte enables are, and clears bits 31:24. A read returns bits 23:0 with bits 31:24 zero.
- R5: In mode 2'b11 (16-bit), a write loads lanes 0 and 1 whatever the byte enables are, and clears bits 31:16. A read returns bits 15:0 with bits 31:16 zero.
- R6: The register is selected in mode 2'b01 when `host_addr` equals `PCI_BASE + 0x18`, and in modes 2'b10 and 2'b11 when `host_addr[10:3]` equals `UB_BASE`. Mode 2'b00 selects nothing. An unselected access changes nothing and reads zero.
- R7: Reserved bits (all bits other than 0, 7:1 and 15) read as zero and ignore written values.
- R8: While `irq_valid` is high and `irq_ready` is low, the request and its vector and non-maskable flag hold unless a host write occurs.
- R9: An edge with `irq_valid` and `irq_ready` both high, and no host write, clears the command bit, so `irq_valid` is low after that edge.
- R10: A host write in the same cycle as an acknowledge takes priority: the written image is stored, including a command bit of 1.
- R11: `irq_ready` while `irq_valid` is low has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode | input | 2 | Bus mode: 00 off, 01 32-bit, 10 24-bit, 11 16-bit |
| host_valid | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host access address |
| host_be | input | 4 | Active-high byte enables (32-bit mode only) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, combinational during a selected read |
| irq_valid | output | 1 | Interrupt request to the core |
| irq_ready | input | 1 | Core acknowledge |
| irq_vector | output | 7 | Requested interrupt vector |
| irq_nmi | output | 1 | Request is non-maskable |

## Verification
The assertions assume that `host_valid` is a single-cycle strobe qualified by a known `host_wr`, and that `host_mode` is steady around each access. They also assume that the core raises `irq_ready` only as an acknowledge and never drops a request. The stimulus changes inputs only just after a rising edge and pulses each access for exactly one cycle. It changes the mode only while no access is in flight. It holds `irq_ready` low for several cycles so that the hold property is exercised, and it raises `irq_ready` with no request pending and together with a write.

// File: rtl/hcv_pkg.sv
package hcv_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int VEC_W   = 7;
  localparam int HC_BIT  = 0;
  localparam int VEC_LSB = 1;
  localparam int NMI_BIT = 15;
  localparam logic [DATA_W-1:0] IMPL_MASK = 32'h0000_80FF;
  localparam logic [DATA_W-1:0] W24_MASK  = 32'h00FF_FFFF;
  localparam logic [DATA_W-1:0] W16_MASK  = 32'h0000_FFFF;

  typedef enum logic [1:0] {
    HM_OFF  = 2'b00,
    HM_W32  = 2'b01,
    HM_W24  = 2'b10,
    HM_W16  = 2'b11
  } hmode_e;

  function automatic int lanes_of(hmode_e m);
    case (m)
      HM_W24:  return 3;
      HM_W16:  return 2;
      default: return LANES;
    endcase
  endfunction
endpackage

// File: rtl/hcv_decode.sv
module hcv_decode
  import hcv_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] PCI_BASE = 32'h0004_0000,
  parameter logic [7:0]      UB_BASE  = 8'h5A
) (
  input  hmode_e            mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] REG_ADDR = PCI_BASE + ADDR_W'('h18);

  always_comb begin
    case (mode)
      HM_W32:         hit = (addr == REG_ADDR);
      HM_W24, HM_W16: hit = (addr[10:3] == UB_BASE);
      default:        hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/hcv_lane_merge.sv
module hcv_lane_merge
  import hcv_pkg::*;
(
  input  hmode_e              mode,
  input  logic [LANES-1:0]    be,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   cur,
  output logic [DATA_W-1:0]   merged
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic en;
    always_comb begin
      if (mode == HM_W32) en = be[i];
      else                en = (i < lanes_of(mode));
    end
    always_comb begin
      if (en)                  merged[8*i +: 8] = wdata[8*i +: 8];
      else if (mode == HM_W32) merged[8*i +: 8] = cur[8*i +: 8];
      else                     merged[8*i +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/hcv_store.sv
module hcv_store
  import hcv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_img,
  input  logic              ack,
  output logic [DATA_W-1:0] img
);
  logic [DATA_W-1:0] img_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   img_q <= '0;
    else if (wr_en)               img_q <= wr_img & IMPL_MASK;
    else if (ack && img_q[HC_BIT]) img_q[HC_BIT] <= 1'b0;
  end

  assign img = img_q;

  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (img_q[HC_BIT] && !ack && !wr_en) |=> (img_q[HC_BIT] && $stable(img_q)));
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (img_q[HC_BIT] && ack && !wr_en) |=> !img_q[HC_BIT]);
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_img[HC_BIT]) |=> img_q[HC_BIT]);
  p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!img_q[HC_BIT] && !wr_en) |=> $stable(img_q));
endmodule

// File: rtl/hcv_top.sv
module hcv_top
  import hcv_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] PCI_BASE = 32'h0004_0000,
  parameter logic [7:0]        UB_BASE  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_mode,
  input  logic              host_valid,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [3:0]        host_be,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [6:0]        irq_vector,
  output logic              irq_nmi
);
  hmode_e            mode;
  logic              hit;
  logic              wr_en;
  logic [DATA_W-1:0] img;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] view_mask;

  assign mode = hmode_e'(host_mode);

  hcv_decode #(.ADDR_W(ADDR_W), .PCI_BASE(PCI_BASE), .UB_BASE(UB_BASE)) u_dec (
    .mode (mode),
    .addr (host_addr),
    .hit  (hit)
  );

  hcv_lane_merge u_merge (
    .mode   (mode),
    .be     (host_be),
    .wdata  (host_wdata),
    .cur    (img),
    .merged (merged)
  );

  assign wr_en = host_valid && host_wr && hit;

  hcv_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_img (merged),
    .ack    (irq_ready),
    .img    (img)
  );

  always_comb begin
    case (mode)
      HM_W24:  view_mask = W24_MASK;
      HM_W16:  view_mask = W16_MASK;
      default: view_mask = '1;
    endcase
  end

  assign host_rdata = (host_valid && !host_wr && hit) ? (img & view_mask) : '0;
  assign irq_valid  = img[HC_BIT];
  assign irq_vector = img[VEC_LSB +: VEC_W];
  assign irq_nmi    = img[NMI_BIT];

  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata & ~IMPL_MASK) == '0);
  p_miss_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !hit && !irq_valid) |=> $stable(img));
  p_narrow_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HM_W16) |-> (host_rdata[31:16] == '0));
  p_narrow_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HM_W24) |-> (host_rdata[31:24] == '0));
endmodule

// File: tb/tb_hcv_top.sv
module tb_hcv_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PCI_ADDR = 32'h0004_0018;
  localparam logic [31:0] UB_ADDR  = 32'h0000_02D0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_mode = 2'b01;
  logic        host_valid = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_addr = '0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [6:0]  irq_vector;
  logic        irq_nmi;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hcv_top dut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .host_valid(host_valid),
    .host_wr(host_wr), .host_addr(host_addr), .host_be(host_be),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector), .irq_nmi(irq_nmi)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_irq(input string tag, input bit v, input logic [6:0] vec,
                           input bit nmi);
    check(irq_valid == v, {tag, " valid"}, 32'(irq_valid), 32'(v));
    if (v) begin
      check(irq_vector == vec, {tag, " vector"}, 32'(irq_vector), 32'(vec));
      check(irq_nmi == nmi, {tag, " nmi"}, 32'(irq_nmi), 32'(nmi));
    end
  endtask

  task automatic host_write(input logic [31:0] a, input logic [3:0] be,
                            input logic [31:0] d);
    host_valid = 1; host_wr = 1; host_addr = a; host_be = be; host_wdata = d;
    @(posedge clk); #1;
    host_valid = 0; host_wr = 0;
  endtask

  task automatic host_read(input logic [31:0] a, input logic [31:0] exp,
                           input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    host_valid = 1; host_wr = 0; host_addr = a;
    @(posedge clk); #1;
    host_valid = 0;
  endtask

  // monitor: compares read data at the falling edge against the scoreboard
  always @(negedge clk) begin
    if (host_valid && !host_wr) begin
      if (exp_q.size() == 0) check(0, "monitor underflow", host_rdata, 0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(host_rdata == e, t, host_rdata, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    check_irq("R1 reset", 0, 0, 0);
    host_read(PCI_ADDR, 32'h0, "R1 reset read");

    // R2, R7: full write, reserved bits dropped
    host_write(PCI_ADDR, 4'hF, 32'hFFFF_FFFF);
    check_irq("R2 fields", 1, 7'h7F, 1);
    host_read(PCI_ADDR, 32'h0000_80FF, "R7 reserved read zero");

    // R8 hold under back-pressure
    repeat (3) @(posedge clk);
    #1 check_irq("R8 hold", 1, 7'h7F, 1);

    // R9 acknowledge clears command bit
    irq_ready = 1; @(posedge clk); #1; irq_ready = 0;
    check_irq("R9 ack clears", 0, 0, 0);
    host_read(PCI_ADDR, 32'h0000_80FE, "R9 readback");

    // R11 ready with no request
    irq_ready = 1; repeat (2) @(posedge clk); #1; irq_ready = 0;
    check_irq("R11 idle ready", 0, 0, 0);
    host_read(PCI_ADDR, 32'h0000_80FE, "R11 readback");

    // R3 byte lanes
    host_write(PCI_ADDR, 4'b0001, 32'h0000_0005);
    check_irq("R3 lane0 only", 1, 7'h02, 1);
    host_write(PCI_ADDR, 4'b0010, 32'h0000_0000);
    check_irq("R3 lane1 only", 1, 7'h02, 0);
    host_write(PCI_ADDR, 4'b0000, 32'hFFFF_FFFF);
    host_read(PCI_ADDR, 32'h0000_0005, "R3 no lanes");

    // R6 selection misses
    host_write(32'h0004_0010, 4'hF, 32'h0);
    host_read(32'h0004_0010, 32'h0, "R6 miss read");
    host_read(PCI_ADDR, 32'h0000_0005, "R6 miss write ignored");
    host_mode = 2'b00;
    host_write(PCI_ADDR, 4'hF, 32'h0);
    host_mode = 2'b01;
    host_read(PCI_ADDR, 32'h0000_0005, "R6 mode off ignored");

    // R4 24-bit mode, enables ignored
    host_mode = 2'b10;
    host_write(UB_ADDR, 4'b0000, 32'hFFFF_8033);
    check_irq("R4 write", 1, 7'h19, 1);
    host_read(UB_ADDR, 32'h0000_8033, "R4 read");
    host_write(UB_ADDR + 32'h8, 4'hF, 32'h0);
    host_read(UB_ADDR, 32'h0000_8033, "R6 ub miss");

    // R5 16-bit mode
    host_mode = 2'b11;
    host_write(UB_ADDR, 4'b0000, 32'hFFFF_0011);
    check_irq("R5 write", 1, 7'h08, 0);
    host_read(UB_ADDR, 32'h0000_0011, "R5 read");

    // R10 write and ack together
    irq_ready = 1;
    host_write(UB_ADDR, 4'hF, 32'h0000_0045);
    irq_ready = 0;
    check_irq("R10 write wins", 1, 7'h22, 0);
    irq_ready = 1; @(posedge clk); #1; irq_ready = 0;
    check_irq("R9 ack after R10", 0, 0, 0);

    @(posedge clk); #1;
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule